// File: doc/BRIEF.md
# Calendar Time Counter with Commit-Pending Busy Flags

This block keeps wall-clock time (seconds, minutes and hours) and the calendar date (day, month and year). It advances once per 1 Hz tick pulse. The year is held as a 6-bit offset from a base year of 1970, so it covers 64 years. February's length is taken from a leap flag stored alongside the date.

Software does not load the counters directly. A write to the time word, the date word or the alarm word is captured into a holding register, and that register's busy flag rises. On the next tick the held value replaces the counter, and the flag drops. That tick is the slow-clock boundary, and the loaded value takes the place of the ordinary increment. Software polls the three busy flags before it issues another update.

Top module: `caltime_top`

## Requirements
- R1: After synchronous reset, `time_q` is 0, `date_q` is 0x0000_0101 (day 1, month 1, year offset 0, leap 0), `alarm_q` is 0 and `busy_o` is 0.
- R2: The time word packs seconds in bits [5:0], minutes in bits [13:8] and hours in bits [20:16]. All other bits read as zero.
- R3: The date word packs the day in bits [4:0] and the 1-based month in bits [11:8]. It packs the year offset from 1970 in bits [21:16] and the leap flag in bit 22. All other bits read as zero.
- R4: One cycle after a write strobe, the matching busy flag is 1. The flags are: `busy_o[0]` for date, `busy_o[1]` for time and `busy_o[2]` for alarm. The flag stays 1, and the visible counter keeps its old value, until the write is committed.
- R5: The first tick in a later cycle than the write commits the held value in place of that tick's increment, and clears the flag at the same edge. A second write before the commit overwrites the held value. A tick in the same cycle as a write advances the counter normally and leaves the write pending.
- R6: Seconds roll from 59 to 0 and carry into minutes. Minutes roll from 59 to 0 and carry into hours. Hours roll from 23 to 0 and carry one day into the date.
- R7: Day carry follows month lengths: 30 days for months 4, 6, 9 and 11, and 31 days for the other non-February months. Past the last day, the date goes to day 1 of the next month.
- R8: February has 29 days when the stored leap flag is 1 and 28 days when it is 0. The flag is taken as written, whatever the year.
- R9: Day 31 of month 12 rolls to day 1 of month 1 with the year offset incremented (63 wraps to 0). At that edge the leap flag is recomputed under the Gregorian rule for 1970 plus the new offset.
- R10: A time commit never carries into the date, even when the counter was at 23:59:59.
- R11: A committed alarm write appears unchanged on `alarm_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_date | input | 1 | Write strobe for the date word |
| wr_time | input | 1 | Write strobe for the time word |
| wr_alarm | input | 1 | Write strobe for the alarm word |
| wr_data | input | 32 | Data for whichever strobe is active |
| time_q | output | 32 | Packed hours, minutes and seconds |
| date_q | output | 32 | Packed year, month, day and leap flag |
| alarm_q | output | 32 | Committed alarm word |
| busy_o | output | 3 | Pending flags: [0] date, [1] time, [2] alarm |

## Verification
The range properties on the time and date fields assume that every time or date write carries legal values. Legal means seconds and minutes up to 59, hours up to 23, a month from 1 to 12 and a day that exists in that month. The bench writes only such values, and it moves all time through the ticks. The flag properties assume that `tick` is a single-cycle pulse, and every tick the bench drives lasts exactly one clock. The same-cycle write-and-tick case is driven deliberately, once, to exercise the rule in R5.

// File: rtl/caltime_pkg.sv
package caltime_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 6;

  localparam int SLOT_DATE  = 0;
  localparam int SLOT_TIME  = 1;
  localparam int SLOT_ALARM = 2;
  localparam int NSLOT      = 3;

  function automatic logic [DAY_W-1:0] month_days(input logic [MON_W-1:0] mon,
                                                  input logic leap);
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: month_days = DAY_W'(30);
      4'd2:                    month_days = leap ? DAY_W'(29) : DAY_W'(28);
      default:                 month_days = DAY_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/caltime_slot.sv
module caltime_slot #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  output logic          busy,
  output logic          commit,
  output logic [DW-1:0] pend
);
  // a tick landing with a fresh write leaves the write pending
  assign commit = tick & busy & ~wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      pend <= '0;
    end else begin
      if (wr) begin
        busy <= 1'b1;
        pend <= wdata;
      end else if (commit) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/caltime_hms.sv
module caltime_hms
  import caltime_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [SEC_W-1:0]  ld_sec,
  input  logic [MIN_W-1:0]  ld_min,
  input  logic [HOUR_W-1:0] ld_hour,
  output logic [DW-1:0]     time_q,
  output logic              day_carry
);
  logic [SEC_W-1:0]  sec;
  logic [MIN_W-1:0]  min;
  logic [HOUR_W-1:0] hour;
  logic step, sec_top, min_top, hour_top;

  always_comb begin
    step      = tick & ~load;
    sec_top   = (sec == SEC_W'(59));
    min_top   = (min == MIN_W'(59));
    hour_top  = (hour == HOUR_W'(23));
    day_carry = step & sec_top & min_top & hour_top;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec  <= '0;
      min  <= '0;
      hour <= '0;
    end else if (load) begin
      sec  <= ld_sec;
      min  <= ld_min;
      hour <= ld_hour;
    end else if (step) begin
      if (!sec_top) begin
        sec <= sec + SEC_W'(1);
      end else begin
        sec <= '0;
        if (!min_top) begin
          min <= min + MIN_W'(1);
        end else begin
          min  <= '0;
          hour <= hour_top ? '0 : hour + HOUR_W'(1);
        end
      end
    end
  end

  assign time_q = DW'({hour, 2'b00, min, 2'b00, sec});
endmodule

// File: rtl/caltime_ymd.sv
module caltime_ymd
  import caltime_pkg::*;
#(
  parameter int DW        = 32,
  parameter int BASE_YEAR = 1970
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DAY_W-1:0]  ld_day,
  input  logic [MON_W-1:0]  ld_mon,
  input  logic [YEAR_W-1:0] ld_year,
  input  logic              ld_leap,
  input  logic              day_carry,
  output logic [DW-1:0]     date_q
);
  logic [DAY_W-1:0]  day;
  logic [MON_W-1:0]  mon;
  logic [YEAR_W-1:0] year;
  logic              leap;
  logic [YEAR_W-1:0] year_nx;
  logic              last_day;

  function automatic logic leap_of(input logic [YEAR_W-1:0] y);
    int full;
    full = BASE_YEAR + int'(y);
    leap_of = ((full % 4 == 0) && (full % 100 != 0)) || (full % 400 == 0);
  endfunction

  always_comb begin
    year_nx  = year + YEAR_W'(1);
    last_day = (day == month_days(mon, leap));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      day  <= DAY_W'(1);
      mon  <= MON_W'(1);
      year <= '0;
      leap <= 1'b0;
    end else if (load) begin
      day  <= ld_day;
      mon  <= ld_mon;
      year <= ld_year;
      leap <= ld_leap;
    end else if (day_carry) begin
      if (!last_day) begin
        day <= day + DAY_W'(1);
      end else begin
        day <= DAY_W'(1);
        if (mon == MON_W'(12)) begin
          mon  <= MON_W'(1);
          year <= year_nx;
          leap <= leap_of(year_nx);
        end else begin
          mon <= mon + MON_W'(1);
        end
      end
    end
  end

  assign date_q = DW'({leap, year, 4'b0000, mon, 3'b000, day});
endmodule

// File: rtl/caltime_top.sv
module caltime_top
  import caltime_pkg::*;
#(
  parameter int DW        = 32,
  parameter int BASE_YEAR = 1970
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_date,
  input  logic          wr_time,
  input  logic          wr_alarm,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] time_q,
  output logic [DW-1:0] date_q,
  output logic [DW-1:0] alarm_q,
  output logic [NSLOT-1:0] busy_o
);
  logic [NSLOT-1:0] wr_vec;
  logic [NSLOT-1:0] commit;
  logic [DW-1:0]    pend [NSLOT];
  logic             day_carry;

  assign wr_vec = {wr_alarm, wr_time, wr_date};

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    caltime_slot #(.DW(DW)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .wr     (wr_vec[i]),
      .wdata  (wr_data),
      .tick   (tick),
      .busy   (busy_o[i]),
      .commit (commit[i]),
      .pend   (pend[i])
    );
  end

  caltime_hms #(.DW(DW)) u_hms (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .load      (commit[SLOT_TIME]),
    .ld_sec    (pend[SLOT_TIME][5:0]),
    .ld_min    (pend[SLOT_TIME][13:8]),
    .ld_hour   (pend[SLOT_TIME][20:16]),
    .time_q    (time_q),
    .day_carry (day_carry)
  );

  caltime_ymd #(.DW(DW), .BASE_YEAR(BASE_YEAR)) u_ymd (
    .clk       (clk),
    .rst       (rst),
    .load      (commit[SLOT_DATE]),
    .ld_day    (pend[SLOT_DATE][4:0]),
    .ld_mon    (pend[SLOT_DATE][11:8]),
    .ld_year   (pend[SLOT_DATE][21:16]),
    .ld_leap   (pend[SLOT_DATE][22]),
    .day_carry (day_carry),
    .date_q    (date_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                    alarm_q <= '0;
    else if (commit[SLOT_ALARM]) alarm_q <= pend[SLOT_ALARM];
  end
endmodule

// File: rtl/caltime_chk.sv
module caltime_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          wr_date,
  input logic          wr_time,
  input logic [DW-1:0] time_q,
  input logic [DW-1:0] date_q,
  input logic [2:0]    busy_o
);
  // R4
  time_busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_time |=> busy_o[1]);

  // R4
  date_busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_date |=> busy_o[0]);

  // R5
  time_busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o[1] && tick && !wr_time) |=> !busy_o[1]);

  // R4
  time_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(time_q));

  // R4
  date_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(date_q));

  // R6
  hms_range_chk: assert property (@(posedge clk) disable iff (rst)
    (time_q[5:0] <= 6'd59) && (time_q[13:8] <= 6'd59) && (time_q[20:16] <= 5'd23));

  // R7
  ymd_range_chk: assert property (@(posedge clk) disable iff (rst)
    (date_q[4:0] >= 5'd1) && (date_q[11:8] >= 4'd1) && (date_q[11:8] <= 4'd12));

  // R10
  no_commit_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o[1] && tick && !wr_time && !busy_o[0]) |=> $stable(date_q));
endmodule

bind caltime_top caltime_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .wr_date (wr_date),
  .wr_time (wr_time),
  .time_q  (time_q),
  .date_q  (date_q),
  .busy_o  (busy_o)
);

// File: tb/caltime_top_tb.sv
module caltime_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_date = 1'b0;
  logic        wr_time = 1'b0;
  logic        wr_alarm = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] time_q, date_q, alarm_q;
  logic [2:0]  busy_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  caltime_top u_dut (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_date(wr_date), .wr_time(wr_time), .wr_alarm(wr_alarm),
    .wr_data(wr_data), .time_q(time_q), .date_q(date_q),
    .alarm_q(alarm_q), .busy_o(busy_o)
  );

  function automatic logic [31:0] pk_t(input int h, input int m, input int s);
    pk_t = {11'b0, 5'(h), 2'b0, 6'(m), 2'b0, 6'(s)};
  endfunction

  function automatic logic [31:0] pk_d(input int y, input int mo, input int d, input int lp);
    pk_d = {9'b0, 1'(lp), 6'(y), 4'b0, 4'(mo), 3'b0, 5'(d)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_t(input logic [31:0] v);
    @(negedge clk); wr_time = 1'b1; wr_data = v;
    @(negedge clk); wr_time = 1'b0;
  endtask

  task automatic wr_d(input logic [31:0] v);
    @(negedge clk); wr_date = 1'b1; wr_data = v;
    @(negedge clk); wr_date = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_both(input logic [31:0] t, input logic [31:0] d);
    wr_t(t);
    wr_d(d);
    do_tick();
  endtask

  task automatic t_reset();
    chk("R1 time", time_q, 32'h0);
    chk("R1 date", date_q, 32'h0000_0101);
    chk("R1 alarm", alarm_q, 32'h0);
    chk("R1 busy", {29'b0, busy_o}, 32'h0);
  endtask

  task automatic t_busy_hold();
    wr_t(pk_t(10, 20, 30));
    chk("R4 busy time", {29'b0, busy_o}, 32'h2);
    repeat (5) @(negedge clk);
    chk("R4 busy held", {29'b0, busy_o}, 32'h2);
    chk("R4 old time visible", time_q, 32'h0);
  endtask

  task automatic t_commit();
    do_tick();
    chk("R5 commit replaces step", time_q, pk_t(10, 20, 30));
    chk("R2 packing", time_q, 32'h000A_141E);
    chk("R5 busy cleared", {29'b0, busy_o}, 32'h0);
    wr_t(pk_t(1, 1, 1));
    wr_t(pk_t(2, 2, 2));
    do_tick();
    chk("R5 last write wins", time_q, pk_t(2, 2, 2));
    wr_t(pk_t(12, 0, 0));
    do_tick();
    @(negedge clk); tick = 1'b1; wr_time = 1'b1; wr_data = pk_t(7, 0, 0);
    @(negedge clk); tick = 1'b0; wr_time = 1'b0;
    chk("R5 same-cycle tick steps", time_q, pk_t(12, 0, 1));
    chk("R5 same-cycle stays busy", {29'b0, busy_o}, 32'h2);
    do_tick();
    chk("R5 next tick commits", time_q, pk_t(7, 0, 0));
  endtask

  task automatic t_carry();
    wr_t(pk_t(0, 0, 59)); do_tick(); do_tick();
    chk("R6 sec carry", time_q, pk_t(0, 1, 0));
    wr_t(pk_t(0, 59, 59)); do_tick(); do_tick();
    chk("R6 min carry", time_q, pk_t(1, 0, 0));
  endtask

  task automatic t_months();
    set_both(pk_t(23, 59, 59), pk_d(0, 4, 30, 0));
    do_tick();
    chk("R6 hour wrap", time_q, pk_t(0, 0, 0));
    chk("R7 30-day month", date_q, pk_d(0, 5, 1, 0));
    set_both(pk_t(23, 59, 59), pk_d(3, 1, 30, 0));
    do_tick();
    chk("R7 mid 31-day month", date_q, pk_d(3, 1, 31, 0));
    set_both(pk_t(23, 59, 59), pk_d(3, 7, 31, 0));
    do_tick();
    chk("R7 31-day month", date_q, pk_d(3, 8, 1, 0));
    chk("R3 packing", date_q, 32'h0003_0801);
  endtask

  task automatic t_feb();
    set_both(pk_t(23, 59, 59), pk_d(30, 2, 28, 1));
    do_tick();
    chk("R8 leap feb 29", date_q, pk_d(30, 2, 29, 1));
    wr_t(pk_t(23, 59, 59)); do_tick(); do_tick();
    chk("R8 leap feb end", date_q, pk_d(30, 3, 1, 1));
    set_both(pk_t(23, 59, 59), pk_d(31, 2, 28, 0));
    do_tick();
    chk("R8 common feb end", date_q, pk_d(31, 3, 1, 0));
    set_both(pk_t(23, 59, 59), pk_d(31, 2, 28, 1));
    do_tick();
    chk("R8 written flag honoured", date_q, pk_d(31, 2, 29, 1));
  endtask

  task automatic t_year();
    set_both(pk_t(23, 59, 59), pk_d(29, 12, 31, 0));
    do_tick();
    chk("R9 year step leap recompute", date_q, pk_d(30, 1, 1, 1));
    set_both(pk_t(23, 59, 59), pk_d(30, 12, 31, 1));
    do_tick();
    chk("R9 leap cleared", date_q, pk_d(31, 1, 1, 0));
    set_both(pk_t(23, 59, 59), pk_d(63, 12, 31, 0));
    do_tick();
    chk("R9 year wrap", date_q, pk_d(0, 1, 1, 0));
  endtask

  task automatic t_nocarry();
    set_both(pk_t(23, 59, 59), pk_d(5, 6, 10, 0));
    wr_t(pk_t(8, 0, 0));
    do_tick();
    chk("R10 time loaded", time_q, pk_t(8, 0, 0));
    chk("R10 date unchanged", date_q, pk_d(5, 6, 10, 0));
  endtask

  task automatic t_alarm();
    @(negedge clk); wr_alarm = 1'b1; wr_data = 32'h0003_1234;
    @(negedge clk); wr_alarm = 1'b0;
    chk("R11 alarm busy", {29'b0, busy_o}, 32'h4);
    chk("R11 alarm not yet", alarm_q, 32'h0);
    do_tick();
    chk("R11 alarm committed", alarm_q, 32'h0003_1234);
    chk("R11 alarm busy clear", {29'b0, busy_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_busy_hold();
    t_commit();
    t_carry();
    t_months();
    t_feb();
    t_year();
    t_nocarry();
    t_alarm();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule